// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a two-channel PCM stream carried on three wires: a bit clock, a word clock that marks which channel is on the line, and one serial data line. It turns the stream into a pair of parallel 24-bit words, one for each channel, and raises a one-cycle strobe when both words of a sample instant are ready. The bit clock is the block's clock. The data line and the word clock are both sampled on its rising edge.

A 3-bit format code selects one of eight framings. There are three framing families. In the right-justified family, a word ends at the word-clock edge. In the left-justified family, a word starts at that edge. The I2S-style family is left-justified with its first bit one bit clock late. Word lengths are 16, 20 or 24 bits. A separate polarity input chooses which word-clock level marks the left channel. Shorter words are placed at the top of the 24-bit output, so the sign bit is always bit 23.

Top module: `serial_audio_rx`

## Requirements
- R1: Serial data and the word clock are sampled on the rising edge of `bclk_i`. Each word arrives most significant bit first. A channel's half-frame starts at the first edge that samples a new word-clock level.
- R2: In the right-justified formats, the word is the last W bits sampled before the word-clock change. Any bits earlier in that half-frame are ignored.
- R3: In the left-justified formats, the word is the first W bits of the half-frame, starting at the edge that sees the new word-clock level. Bits after those W are ignored.
- R4: In the I2S formats, the first bit of a half-frame is skipped. The word is the W bits that follow it.
- R5: The format code `fmt_i` selects the framing and the width W as follows:
  - 0: right-justified, 16 bits
  - 1: right-justified, 20 bits
  - 2: right-justified, 24 bits
  - 3: left-justified, 24 bits
  - 4: I2S, 16 bits
  - 5: I2S, 24 bits
  - 6: I2S, 20 bits
  - 7: left-justified, 20 bits
- R6: With `lr_pol_i` at 0, word clock high marks the left channel. With `lr_pol_i` at 1, word clock low marks the left channel. In every sample instant the left word comes first.
- R7: A received W-bit word appears in bits 23 down to 24-W of its output. The lower 24-W bits are zero.
- R8: `valid_o` is high for exactly one cycle. That cycle follows the edge that samples the word clock entering the left level after a complete right word. At that point `left_o` and `right_o` together show one left/right pair. The outputs change at no other time.
- R9: During and after reset, `valid_o` and both outputs are zero. The half-frame that is partly under way when reset releases is discarded. No strobe occurs until a left word and then a right word have completed after the first word-clock change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk_i | input | 1 | Serial bit clock; the block's clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lrck_i | input | 1 | Word clock (channel select) |
| sdata_i | input | 1 | Serial audio data |
| fmt_i | input | 3 | Framing and width code |
| lr_pol_i | input | 1 | Word-clock polarity select |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The bench builds the block with its default 24-bit sample width and a 6-bit slot counter. It sweeps all eight format codes against both polarities and two half-frame lengths. The 25-bit half-frame is the tightest length that still fits a delayed 24-bit word. The 32-bit half-frame adds leading padding in the right-justified formats and trailing padding in the left-justified ones, and that padding is set to ones so that a misplaced capture window shows up. Each run starts with a partial half-frame that must be discarded, so the start-up rule is exercised under every configuration.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

  localparam int SAMPLE_W = 24;

  // Framing description derived from the 3-bit format code
  typedef struct packed {
    logic       lead_skip;    // one idle bit before the MSB
    logic       msb_at_start; // word is anchored to the start of the half-frame
    logic [4:0] bits;         // word length in bits
  } frame_cfg_t;

  function automatic frame_cfg_t decode_fmt(input logic [2:0] code);
    frame_cfg_t c;
    case (code)
      3'd0:    c = '{lead_skip: 1'b0, msb_at_start: 1'b0, bits: 5'd16};
      3'd1:    c = '{lead_skip: 1'b0, msb_at_start: 1'b0, bits: 5'd20};
      3'd2:    c = '{lead_skip: 1'b0, msb_at_start: 1'b0, bits: 5'd24};
      3'd3:    c = '{lead_skip: 1'b0, msb_at_start: 1'b1, bits: 5'd24};
      3'd4:    c = '{lead_skip: 1'b1, msb_at_start: 1'b1, bits: 5'd16};
      3'd5:    c = '{lead_skip: 1'b1, msb_at_start: 1'b1, bits: 5'd24};
      3'd6:    c = '{lead_skip: 1'b1, msb_at_start: 1'b1, bits: 5'd20};
      default: c = '{lead_skip: 1'b0, msb_at_start: 1'b1, bits: 5'd20};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/audrx_fmt_dec.sv
module audrx_fmt_dec
  import audrx_pkg::*;
(
  input  logic [2:0] fmt_i,
  output frame_cfg_t cfg_o
);

  always_comb begin
    cfg_o = decode_fmt(fmt_i);
  end

endmodule

// File: rtl/audrx_capture.sv
module audrx_capture
  import audrx_pkg::*;
#(
  parameter int W     = SAMPLE_W,
  parameter int IDX_W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sdata_i,
  input  logic         edge_i,
  input  frame_cfg_t   cfg_i,
  output logic [W-1:0] word_o
);

  localparam int SH_W = $clog2(W + 1);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [W-1:0]     hist_q, hist_d;
  logic [W-1:0]     cap_q, cap_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             cap_en;
  logic [IDX_W-1:0] cur_idx;
  logic [IDX_W:0]   win_lo, win_hi, cur_ext;
  logic [W-1:0]     src;
  logic [SH_W-1:0]  shamt;

  // Position of the bit sampled at this edge within its half-frame
  always_comb begin
    cur_idx = edge_i ? '0 : idx_q;
    cur_ext = {1'b0, cur_idx};
    win_lo  = (IDX_W+1)'(cfg_i.lead_skip);
    win_hi  = win_lo + (IDX_W+1)'(cfg_i.bits);
    cap_en  = cfg_i.msb_at_start && (cur_ext >= win_lo) && (cur_ext < win_hi);
  end

  always_comb begin
    hist_d = {hist_q[W-2:0], sdata_i};
    cap_d  = cap_en ? {cap_q[W-2:0], sdata_i} : cap_q;
    if (edge_i)                idx_d = IDX_W'(1);
    else if (idx_q == IDX_MAX) idx_d = idx_q;
    else                       idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      cap_q  <= '0;
      idx_q  <= '0;
    end else begin
      hist_q <= hist_d;
      cap_q  <= cap_d;
      idx_q  <= idx_d;
    end
  end

  // Word of the half-frame that ends at this edge, moved to the top bits
  always_comb begin
    src    = cfg_i.msb_at_start ? cap_q : hist_q;
    shamt  = SH_W'(W) - SH_W'(cfg_i.bits);
    word_o = src << shamt;
  end

endmodule

// File: rtl/audrx_framer.sv
module audrx_framer
  import audrx_pkg::*;
#(
  parameter int W = SAMPLE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         lrck_i,
  input  logic         lr_pol_i,
  input  logic [W-1:0] word_i,
  output logic         edge_o,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o
);

  logic         lrck_q, primed_q, synced_q, have_left_q, valid_q;
  logic         synced_d, have_left_d, valid_d;
  logic [W-1:0] hold_q, hold_d, left_q, left_d, right_q, right_d;
  logic         prev_left, store_left, emit;

  always_comb begin
    edge_o      = primed_q && (lrck_i != lrck_q);
    prev_left   = lrck_q ^ lr_pol_i;
    store_left  = edge_o && synced_q && prev_left;
    emit        = edge_o && synced_q && !prev_left && have_left_q;
    synced_d    = synced_q || edge_o;
    hold_d      = store_left ? word_i : hold_q;
    if (store_left) have_left_d = 1'b1;
    else if (emit)  have_left_d = 1'b0;
    else            have_left_d = have_left_q;
    valid_d     = emit;
    left_d      = emit ? hold_q : left_q;
    right_d     = emit ? word_i : right_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lrck_q      <= 1'b0;
      primed_q    <= 1'b0;
      synced_q    <= 1'b0;
      have_left_q <= 1'b0;
      valid_q     <= 1'b0;
      hold_q      <= '0;
      left_q      <= '0;
      right_q     <= '0;
    end else begin
      lrck_q      <= lrck_i;
      primed_q    <= 1'b1;
      synced_q    <= synced_d;
      have_left_q <= have_left_d;
      valid_q     <= valid_d;
      hold_q      <= hold_d;
      left_q      <= left_d;
      right_q     <= right_d;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import audrx_pkg::*;
#(
  parameter int SLOT_CNT_W = 6
) (
  input  logic                bclk_i,
  input  logic                rst_ni,
  input  logic                lrck_i,
  input  logic                sdata_i,
  input  logic [2:0]          fmt_i,
  input  logic                lr_pol_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);

  frame_cfg_t          cfg;
  logic                edge_hit;
  logic [SAMPLE_W-1:0] word;

  audrx_fmt_dec u_dec (
    .fmt_i (fmt_i),
    .cfg_o (cfg)
  );

  audrx_capture #(.W(SAMPLE_W), .IDX_W(SLOT_CNT_W)) u_cap (
    .clk_i   (bclk_i),
    .rst_ni  (rst_ni),
    .sdata_i (sdata_i),
    .edge_i  (edge_hit),
    .cfg_i   (cfg),
    .word_o  (word)
  );

  audrx_framer #(.W(SAMPLE_W)) u_frm (
    .clk_i    (bclk_i),
    .rst_ni   (rst_ni),
    .lrck_i   (lrck_i),
    .lr_pol_i (lr_pol_i),
    .word_i   (word),
    .edge_o   (edge_hit),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o)
  );

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk (
  input logic        bclk_i,
  input logic        rst_ni,
  input logic        lrck_i,
  input logic [2:0]  fmt_i,
  input logic        lr_pol_i,
  input logic [23:0] left_o,
  input logic [23:0] right_o,
  input logic        valid_o
);

  AST_STROBE_SINGLE: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R8

  AST_STROBE_AT_LEFT_ENTRY: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    valid_o |-> ($past(lrck_i) ^ $past(lr_pol_i))); // R6

  AST_OUT_HELD: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (!$stable(left_o) || !$stable(right_o)) |-> valid_o); // R8

  AST_NARROW_LSB_ZERO: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (valid_o && ($past(fmt_i) == 3'd0 || $past(fmt_i) == 3'd4))
      |-> (left_o[7:0] == 8'd0 && right_o[7:0] == 8'd0)); // R7

  AST_MID_LSB_ZERO: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (valid_o && ($past(fmt_i) == 3'd1 || $past(fmt_i) == 3'd6 || $past(fmt_i) == 3'd7))
      |-> (left_o[3:0] == 4'd0 && right_o[3:0] == 4'd0)); // R7

endmodule

bind serial_audio_rx serial_audio_rx_chk u_chk (
  .bclk_i   (bclk_i),
  .rst_ni   (rst_ni),
  .lrck_i   (lrck_i),
  .fmt_i    (fmt_i),
  .lr_pol_i (lr_pol_i),
  .left_o   (left_o),
  .right_o  (right_o),
  .valid_o  (valid_o)
);

// File: tb/sim_serial_audio_rx.sv
`timescale 1ns/1ps
module sim_serial_audio_rx;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lrck, sdata, pol;
  logic [2:0]  fmt;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  logic prev_valid = 1'b0;
  logic [47:0] expq[$];

  always #2.5 clk = ~clk;

  serial_audio_rx u0 (
    .bclk_i   (clk),
    .rst_ni   (rst_n),
    .lrck_i   (lrck),
    .sdata_i  (sdata),
    .fmt_i    (fmt),
    .lr_pol_i (pol),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o)
  );

  // Independent format model (R5)
  function automatic int fw(input logic [2:0] f);
    case (f)
      3'd0, 3'd4:       return 16;
      3'd1, 3'd6, 3'd7: return 20;
      default:          return 24;
    endcase
  endfunction
  function automatic bit f_start(input logic [2:0] f);
    return (f == 3'd3 || f == 3'd7 || f[2]);
  endfunction
  function automatic int f_delay(input logic [2:0] f);
    return (f == 3'd4 || f == 3'd5 || f == 3'd6) ? 1 : 0;
  endfunction
  function automatic string f_tag(input logic [2:0] f);
    if (f_delay(f) == 1) return "R4";
    if (f_start(f))      return "R3";
    return "R2";
  endfunction

  // Monitor: sample away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o && prev_valid) begin
        checks++; errors++;
        $display("FAIL R8 strobe longer than one cycle: actual=2 expected=1");
      end
      if (valid_o) begin
        pulses++;
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R9 strobe with no frame pending: actual=%h/%h expected=none", left_o, right_o);
        end else begin
          logic [47:0] e;
          e = expq.pop_front();
          if ({left_o, right_o} !== e) begin
            errors++;
            $display("FAIL %s/R1/R5/R6/R7 fmt=%0d pol=%0b: actual=%h/%h expected=%h/%h",
                     f_tag(fmt), fmt, pol, left_o, right_o, e[47:24], e[23:0]);
          end
        end
      end
    end
    prev_valid = valid_o;
  end

  task automatic drive_bit(input logic lr, input logic d);
    @(negedge clk);
    lrck  = lr;
    sdata = d;
  endtask

  task automatic send_half(input logic lr, input logic [23:0] w, input int slot);
    int n;
    n = fw(fmt);
    for (int i = 0; i < slot; i++) begin
      logic b;
      b = 1'b1;
      if (f_start(fmt)) begin
        int j;
        j = i - f_delay(fmt);
        if (j >= 0 && j < n) b = w[n-1-j];
      end else begin
        int p;
        p = slot - 1 - i;
        if (p < n) b = w[p];
      end
      drive_bit(lr, b);
    end
  endtask

  task automatic run_cfg(input logic [2:0] f, input logic p, input int slot);
    logic lv, rv;
    int n;
    int base;
    n  = fw(f);
    lv = ~p;
    rv = p;
    @(negedge clk);
    rst_n = 1'b0;
    fmt = f; pol = p; lrck = rv; sdata = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.1;
    checks++;
    if (valid_o !== 1'b0 || left_o !== 24'd0 || right_o !== 24'd0) begin
      errors++;
      $display("FAIL R9 reset state: actual=%b/%h/%h expected=0/0/0", valid_o, left_o, right_o);
    end
    pulses = 0;
    send_half(rv, 24'hFFFFFF, slot); // partial half before sync: discarded
    for (int k = 0; k < 3; k++) begin
      logic [23:0] l, r, mask;
      mask = 24'hFFFFFF >> (24 - n);
      l = 24'((k * 37 + int'(f) * 11 + slot) * 32'h1F3A7) ^ 24'hA5C3D1;
      r = 24'((k * 53 + int'(f) * 7 + slot + 5) * 32'h2B1D5) ^ 24'h5A3C96;
      l = l & mask;
      r = r & mask;
      expq.push_back({24'(l << (24 - n)), 24'(r << (24 - n))});
      send_half(lv, l, slot);
      send_half(rv, r, slot);
    end
    send_half(lv, 24'd0, slot);
    repeat (4) @(negedge clk);
    checks++;
    if (pulses != 3 || expq.size() != 0) begin
      errors++;
      $display("FAIL R8/R9 strobe count fmt=%0d pol=%0b slot=%0d: actual=%0d expected=3",
               f, p, slot, pulses);
      expq.delete();
    end
  endtask

  initial begin
    rst_n = 1'b0; lrck = 1'b0; sdata = 1'b0; fmt = 3'd0; pol = 1'b0;
    for (int f = 0; f < 8; f++)
      for (int p = 0; p < 2; p++) begin
        run_cfg(3'(f), 1'(p), 25);
        run_cfg(3'(f), 1'(p), 32);
      end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule